// File: doc/BRIEF.md
# Mailbox and Doorbell Interrupt Unit

This block passes short messages and doorbell events between a host bus master and a local processor. Each side has its own simple register port: a 3-bit word index, a write strobe, write data, and combinational read data. There are two 32-bit message registers in each direction and one doorbell register in each direction. Both ports can read all message and doorbell registers. Only the proper side may write a given register.

Writing a message register flags that message in the status of its direction. Doorbell bits are posted by one side and cleared by the other, using write-one-to-clear. Each direction has a status view and a mask. The status view shows the raw events with the masked ones removed. The host interrupt covers outbound events and the local interrupt covers inbound events. Each interrupt is a registered level that is high while any enabled event is pending.

The queue-related status bits (machine check, post-queue-not-empty and the two overflow flags) reflect levels driven by queue logic outside this block.

Top module: `mbx_unit`

## Requirements
- R1: After reset, all message registers, both doorbells and both message status pairs are zero. Both mask registers read 32'hFFFFFFFF, and both interrupts are low.
- R2: Each port uses the same word indices: 0/1 = inbound message 0/1, 2/3 = outbound message 0/1, 4 = inbound doorbell, 5 = outbound doorbell, 6 = status view of the port's own direction, 7 = mask of the port's own direction. Only the host writes indices 0/1 and only the local port writes indices 2/3. A write from the other port leaves the register unchanged.
- R3: Writing message register k sets message status bit k of its direction (bit 0 or bit 1). Writing 1 to bit k of the status index (6) of that direction clears it. A set and a clear in the same cycle leave the bit set.
- R4: A host write to index 4 ORs the data into the inbound doorbell. A local write to index 5 ORs only data bits 28:0 into the outbound doorbell, so bits 31:29 of that doorbell always read zero.
- R5: A local write to index 4 clears each inbound doorbell bit written as 1. A host write to index 5 does the same for the outbound doorbell. When a bit is posted and cleared in the same cycle, it is left set.
- R6: Status bit 3 of each direction is high while any bit of that direction's doorbell is set. Writing the status index does not clear it.
- R7: Inbound status bit 4 follows mchk_i, bit 5 follows ipq_nempty_i, bit 7 follows ipq_ovf_i and bit 8 follows ofq_ovf_i. Outbound status bit 5 follows opq_nempty_i. None of these is cleared by a status write.
- R8: The mask index (7) is a full read/write word. A mask bit of 1 disables its source and a mask bit of 0 enables it.
- R9: The status view reads raw status AND NOT mask over the defined bits only. The defined bits are inbound 0,1,3,4,5,7,8 and outbound 0,1,3,5. All other bits read zero.
- R10: Each interrupt output is high in a cycle exactly when its direction's status view was non-zero in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 3 | Host port word index |
| h_we | input | 1 | Host write strobe |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for h_addr |
| l_addr | input | 3 | Local port word index |
| l_we | input | 1 | Local write strobe |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data for l_addr |
| mchk_i | input | 1 | Machine-check request level |
| ipq_nempty_i | input | 1 | Inbound post queue not empty |
| ipq_ovf_i | input | 1 | Inbound post queue overflow |
| ofq_ovf_i | input | 1 | Outbound free queue overflow |
| opq_nempty_i | input | 1 | Outbound post queue not empty |
| host_irq | output | 1 | Outbound-event interrupt to the host |
| local_irq | output | 1 | Inbound-event interrupt to the local processor |

## Verification
The bench builds the block with its defaults: a 32-bit word and three reserved outbound doorbell bits. With these values the reserved field sits at bits 31:29, and full-width random doorbell posts reach it. Random masks often leave only one or two sources enabled. This makes each interrupt depend on single status bits. It also brings posts and clears from the two ports into the same cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Word indices, shared by both ports
    typedef enum logic [2:0] {
        IDX_IMSG0 = 3'd0,
        IDX_IMSG1 = 3'd1,
        IDX_OMSG0 = 3'd2,
        IDX_OMSG1 = 3'd3,
        IDX_IDB   = 3'd4,
        IDX_ODB   = 3'd5,
        IDX_STAT  = 3'd6,
        IDX_MASK  = 3'd7
    } mbx_idx_e;

    // Status and mask bit positions
    localparam int unsigned BIT_MSG0 = 0;
    localparam int unsigned BIT_MSG1 = 1;
    localparam int unsigned BIT_DB   = 3;
    localparam int unsigned BIT_MC   = 4;
    localparam int unsigned BIT_PQ   = 5;
    localparam int unsigned BIT_POVF = 7;
    localparam int unsigned BIT_FOVF = 8;

    // Defined-bit sets of each direction
    localparam logic [8:0] IN_DEF_BITS  = 9'h1BB;
    localparam logic [8:0] OUT_DEF_BITS = 9'h02B;

    localparam int unsigned NUM_MSG = 2;

endpackage

// File: rtl/mbx_msg_pair.sv
module mbx_msg_pair #(
    parameter int DATA_W = 32,
    parameter int NUM    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM-1:0]             wr_en,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [NUM-1:0]             clr,
    output logic [NUM-1:0][DATA_W-1:0] msg_o,
    output logic [NUM-1:0]             stat_o
);

    for (genvar k = 0; k < NUM; k++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                msg_o[k]  <= '0;
                stat_o[k] <= 1'b0;
            end else begin
                if (wr_en[k]) begin
                    msg_o[k] <= wdata;
                end
                if (wr_en[k]) begin
                    stat_o[k] <= 1'b1;
                end else if (clr[k]) begin
                    stat_o[k] <= 1'b0;
                end
            end
        end

        // R3
        msg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[k] |=> (stat_o[k] && msg_o[k] == $past(wdata)));

        // R3
        msg_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[k] && !wr_en[k]) |=> !stat_o[k]);
    end

endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell #(
    parameter int DATA_W = 32,
    parameter int LIVE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [DATA_W-1:0] set_val,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_val,
    output logic [DATA_W-1:0] db_o,
    output logic              pend_o
);

    localparam logic [DATA_W-1:0] LIVE = (LIVE_W >= DATA_W) ? '1 :
                                         DATA_W'((64'd1 << LIVE_W) - 64'd1);

    logic [DATA_W-1:0] set_bits;
    logic [DATA_W-1:0] clr_bits;

    always_comb begin
        set_bits = set_en ? (set_val & LIVE) : '0;
        clr_bits = clr_en ? clr_val : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            db_o <= '0;
        end else begin
            db_o <= (db_o & ~clr_bits) | set_bits;
        end
    end

    assign pend_o = |db_o;

    // R4
    db_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((db_o & $past(set_val & LIVE)) == $past(set_val & LIVE)));

    // R5
    db_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((db_o & $past(clr_val)) == '0));

endmodule

// File: rtl/mbx_irq_dir.sv
module mbx_irq_dir #(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] DEF    = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] raw_i,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] mask_wdata,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] view_o,
    output logic              irq_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '1;
        end else if (mask_we) begin
            mask_o <= mask_wdata;
        end
    end

    assign view_o = raw_i & ~mask_o & DEF;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |view_o;
        end
    end

    // R8
    mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_o == $past(mask_wdata)));

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(raw_i & DEF)));

endmodule

// File: rtl/mbx_unit.sv
module mbx_unit
    import mbx_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DB_RSVD = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        h_addr,
    input  logic              h_we,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic [2:0]        l_addr,
    input  logic              l_we,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              mchk_i,
    input  logic              ipq_nempty_i,
    input  logic              ipq_ovf_i,
    input  logic              ofq_ovf_i,
    input  logic              opq_nempty_i,
    output logic              host_irq,
    output logic              local_irq
);

    localparam int                DB_LIVE = DATA_W - DB_RSVD;
    localparam logic [DATA_W-1:0] IN_DEF  = DATA_W'(IN_DEF_BITS);
    localparam logic [DATA_W-1:0] OUT_DEF = DATA_W'(OUT_DEF_BITS);

    mbx_idx_e h_sel;
    mbx_idx_e l_sel;
    assign h_sel = mbx_idx_e'(h_addr);
    assign l_sel = mbx_idx_e'(l_addr);

    logic [NUM_MSG-1:0]             h_imsg_wr;
    logic [NUM_MSG-1:0]             l_omsg_wr;
    logic [NUM_MSG-1:0]             ist_clr;
    logic [NUM_MSG-1:0]             ost_clr;
    logic [NUM_MSG-1:0][DATA_W-1:0] imsg;
    logic [NUM_MSG-1:0][DATA_W-1:0] omsg;
    logic [NUM_MSG-1:0]             ist;
    logic [NUM_MSG-1:0]             ost;
    logic [DATA_W-1:0]              idb;
    logic [DATA_W-1:0]              odb;
    logic                           idb_pend;
    logic                           odb_pend;
    logic [DATA_W-1:0]              raw_in;
    logic [DATA_W-1:0]              raw_out;
    logic [DATA_W-1:0]              in_mask;
    logic [DATA_W-1:0]              out_mask;
    logic [DATA_W-1:0]              in_view;
    logic [DATA_W-1:0]              out_view;

    // Write decode
    always_comb begin
        h_imsg_wr[0] = h_we && (h_sel == IDX_IMSG0);
        h_imsg_wr[1] = h_we && (h_sel == IDX_IMSG1);
        l_omsg_wr[0] = l_we && (l_sel == IDX_OMSG0);
        l_omsg_wr[1] = l_we && (l_sel == IDX_OMSG1);
        ist_clr      = (l_we && l_sel == IDX_STAT) ? l_wdata[NUM_MSG-1:0] : '0;
        ost_clr      = (h_we && h_sel == IDX_STAT) ? h_wdata[NUM_MSG-1:0] : '0;
    end

    mbx_msg_pair #(.DATA_W(DATA_W), .NUM(NUM_MSG)) u_in_msg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (h_imsg_wr),
        .wdata  (h_wdata),
        .clr    (ist_clr),
        .msg_o  (imsg),
        .stat_o (ist)
    );

    mbx_msg_pair #(.DATA_W(DATA_W), .NUM(NUM_MSG)) u_out_msg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (l_omsg_wr),
        .wdata  (l_wdata),
        .clr    (ost_clr),
        .msg_o  (omsg),
        .stat_o (ost)
    );

    mbx_doorbell #(.DATA_W(DATA_W), .LIVE_W(DATA_W)) u_in_db (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (h_we && h_sel == IDX_IDB),
        .set_val (h_wdata),
        .clr_en  (l_we && l_sel == IDX_IDB),
        .clr_val (l_wdata),
        .db_o    (idb),
        .pend_o  (idb_pend)
    );

    mbx_doorbell #(.DATA_W(DATA_W), .LIVE_W(DB_LIVE)) u_out_db (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (l_we && l_sel == IDX_ODB),
        .set_val (l_wdata),
        .clr_en  (h_we && h_sel == IDX_ODB),
        .clr_val (h_wdata),
        .db_o    (odb),
        .pend_o  (odb_pend)
    );

    // Raw status assembly
    always_comb begin
        raw_in           = '0;
        raw_in[BIT_MSG0] = ist[0];
        raw_in[BIT_MSG1] = ist[1];
        raw_in[BIT_DB]   = idb_pend;
        raw_in[BIT_MC]   = mchk_i;
        raw_in[BIT_PQ]   = ipq_nempty_i;
        raw_in[BIT_POVF] = ipq_ovf_i;
        raw_in[BIT_FOVF] = ofq_ovf_i;

        raw_out           = '0;
        raw_out[BIT_MSG0] = ost[0];
        raw_out[BIT_MSG1] = ost[1];
        raw_out[BIT_DB]   = odb_pend;
        raw_out[BIT_PQ]   = opq_nempty_i;
    end

    mbx_irq_dir #(.DATA_W(DATA_W), .DEF(IN_DEF)) u_in_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_i      (raw_in),
        .mask_we    (l_we && l_sel == IDX_MASK),
        .mask_wdata (l_wdata),
        .mask_o     (in_mask),
        .view_o     (in_view),
        .irq_o      (local_irq)
    );

    mbx_irq_dir #(.DATA_W(DATA_W), .DEF(OUT_DEF)) u_out_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_i      (raw_out),
        .mask_we    (h_we && h_sel == IDX_MASK),
        .mask_wdata (h_wdata),
        .mask_o     (out_mask),
        .view_o     (out_view),
        .irq_o      (host_irq)
    );

    // Read muxes
    always_comb begin
        h_rdata = '0;
        unique case (h_sel)
            IDX_IMSG0: h_rdata = imsg[0];
            IDX_IMSG1: h_rdata = imsg[1];
            IDX_OMSG0: h_rdata = omsg[0];
            IDX_OMSG1: h_rdata = omsg[1];
            IDX_IDB:   h_rdata = idb;
            IDX_ODB:   h_rdata = odb;
            IDX_STAT:  h_rdata = out_view;
            IDX_MASK:  h_rdata = out_mask;
        endcase
    end

    always_comb begin
        l_rdata = '0;
        unique case (l_sel)
            IDX_IMSG0: l_rdata = imsg[0];
            IDX_IMSG1: l_rdata = imsg[1];
            IDX_OMSG0: l_rdata = omsg[0];
            IDX_OMSG1: l_rdata = omsg[1];
            IDX_IDB:   l_rdata = idb;
            IDX_ODB:   l_rdata = odb;
            IDX_STAT:  l_rdata = in_view;
            IDX_MASK:  l_rdata = in_mask;
        endcase
    end

    // R2
    omsg_host_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_sel == IDX_OMSG0 && !l_omsg_wr[0]) |=> $stable(omsg[0]));

    // R2
    imsg_local_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_we && l_sel == IDX_IMSG1 && !h_imsg_wr[1]) |=> $stable(imsg[1]));

    // R4
    odb_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_sel == IDX_ODB) |-> (h_rdata[DATA_W-1:DB_LIVE] == '0));

    // R6
    db_stat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idb_pend && !(l_we && l_sel == IDX_IDB)) |=> raw_in[BIT_DB]);

endmodule

// File: tb/tb_mbx_unit.sv
module tb_mbx_unit;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;
    localparam logic [31:0] IN_DEF  = 32'h1BB;
    localparam logic [31:0] OUT_DEF = 32'h02B;
    localparam logic [31:0] ODB_LIVE = 32'h1FFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    h_addr = '0;
    logic          h_we = 1'b0;
    logic [DW-1:0] h_wdata = '0;
    logic [DW-1:0] h_rdata;
    logic [2:0]    l_addr = '0;
    logic          l_we = 1'b0;
    logic [DW-1:0] l_wdata = '0;
    logic [DW-1:0] l_rdata;
    logic          mchk_i = 1'b0;
    logic          ipq_nempty_i = 1'b0;
    logic          ipq_ovf_i = 1'b0;
    logic          ofq_ovf_i = 1'b0;
    logic          opq_nempty_i = 1'b0;
    logic          host_irq;
    logic          local_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_unit dut (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_we(h_we), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .l_addr(l_addr), .l_we(l_we), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .mchk_i(mchk_i), .ipq_nempty_i(ipq_nempty_i), .ipq_ovf_i(ipq_ovf_i),
        .ofq_ovf_i(ofq_ovf_i), .opq_nempty_i(opq_nempty_i),
        .host_irq(host_irq), .local_irq(local_irq)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Reference model state
    logic [31:0] m_im [2];
    logic [31:0] m_om [2];
    logic [1:0]  m_ist, m_ost;
    logic [31:0] m_idb, m_odb, m_imask, m_omask;
    logic        m_hirq, m_lirq;

    function automatic logic [31:0] raw_in_f();
        logic [31:0] r = '0;
        r[0] = m_ist[0]; r[1] = m_ist[1]; r[3] = |m_idb;
        r[4] = mchk_i; r[5] = ipq_nempty_i; r[7] = ipq_ovf_i; r[8] = ofq_ovf_i;
        return r;
    endfunction

    function automatic logic [31:0] raw_out_f();
        logic [31:0] r = '0;
        r[0] = m_ost[0]; r[1] = m_ost[1]; r[3] = |m_odb; r[5] = opq_nempty_i;
        return r;
    endfunction

    function automatic logic [31:0] read_f(bit host, logic [2:0] a);
        case (a)
            3'd0: return m_im[0];
            3'd1: return m_im[1];
            3'd2: return m_om[0];
            3'd3: return m_om[1];
            3'd4: return m_idb;
            3'd5: return m_odb;
            3'd6: return host ? (raw_out_f() & ~m_omask & OUT_DEF)
                              : (raw_in_f() & ~m_imask & IN_DEF);
            default: return host ? m_omask : m_imask;
        endcase
    endfunction

    function automatic string tag_f(logic [2:0] a);
        case (a)
            3'd0, 3'd1, 3'd2, 3'd3: return "R2";
            3'd4, 3'd5: return "R4";
            3'd6: return "R9";
            default: return "R8";
        endcase
    endfunction

    task automatic model_reset();
        m_im[0] = '0; m_im[1] = '0; m_om[0] = '0; m_om[1] = '0;
        m_ist = '0; m_ost = '0; m_idb = '0; m_odb = '0;
        m_imask = '1; m_omask = '1; m_hirq = 1'b0; m_lirq = 1'b0;
    endtask

    task automatic model_clock();
        logic [1:0] ist_n, ost_n;
        logic [31:0] idb_n, odb_n;
        m_lirq = |(raw_in_f() & ~m_imask & IN_DEF);
        m_hirq = |(raw_out_f() & ~m_omask & OUT_DEF);
        ist_n = m_ist; ost_n = m_ost; idb_n = m_idb; odb_n = m_odb;
        // clears first, sets afterwards (set wins)
        if (l_we && l_addr == 3'd6) ist_n = ist_n & ~l_wdata[1:0];
        if (h_we && h_addr == 3'd6) ost_n = ost_n & ~h_wdata[1:0];
        if (l_we && l_addr == 3'd4) idb_n = idb_n & ~l_wdata;
        if (h_we && h_addr == 3'd5) odb_n = odb_n & ~h_wdata;
        if (h_we && h_addr == 3'd4) idb_n = idb_n | h_wdata;
        if (l_we && l_addr == 3'd5) odb_n = odb_n | (l_wdata & ODB_LIVE);
        if (h_we && h_addr <= 3'd1) begin
            m_im[h_addr[0]] = h_wdata; ist_n[h_addr[0]] = 1'b1;
        end
        if (l_we && (l_addr == 3'd2 || l_addr == 3'd3)) begin
            m_om[l_addr[0]] = l_wdata; ost_n[l_addr[0]] = 1'b1;
        end
        if (h_we && h_addr == 3'd7) m_omask = h_wdata;
        if (l_we && l_addr == 3'd7) m_imask = l_wdata;
        m_ist = ist_n; m_ost = ost_n; m_idb = idb_n; m_odb = odb_n;
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive just after negedge, check reads, clock, check irqs.
    task automatic cycle(bit hwe, logic [2:0] ha, logic [31:0] hd,
                         bit lwe, logic [2:0] la, logic [31:0] ld, string tag);
        h_we = hwe; h_addr = ha; h_wdata = hd;
        l_we = lwe; l_addr = la; l_wdata = ld;
        #1;
        chk((tag == "") ? tag_f(ha) : tag, $sformatf("host read idx %0d", ha), h_rdata, read_f(1'b1, ha));
        chk((tag == "") ? tag_f(la) : tag, $sformatf("local read idx %0d", la), l_rdata, read_f(1'b0, la));
        @(posedge clk);
        model_clock();
        @(negedge clk);
        chk("R10", "host_irq", {31'b0, host_irq}, {31'b0, m_hirq});
        chk("R10", "local_irq", {31'b0, local_irq}, {31'b0, m_lirq});
    endtask

    task automatic idle_read(logic [2:0] ha, logic [2:0] la, string tag);
        cycle(1'b0, ha, '0, 1'b0, la, '0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0000_5eed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state on every index
        for (int a = 0; a < 8; a++) idle_read(3'(a), 3'(a), "R1");

        // R3: host posts inbound message 0, local unmasks and sees it
        cycle(1'b1, 3'd0, 32'hCAFE_0001, 1'b1, 3'd7, 32'hFFFF_FFFC, "R3");
        idle_read(3'd0, 3'd6, "R3");
        chk("R3", "inbound status msg0", l_rdata, 32'h1);
        // R3: clear and post in the same cycle keeps the bit set
        cycle(1'b1, 3'd0, 32'h1234_5678, 1'b1, 3'd6, 32'h1, "R3");
        idle_read(3'd0, 3'd6, "R3");
        chk("R3", "set beats clear", l_rdata, 32'h1);
        cycle(1'b0, 3'd0, '0, 1'b1, 3'd6, 32'h3, "R3");
        idle_read(3'd0, 3'd6, "R3");
        chk("R3", "W1C clear", l_rdata, 32'h0);

        // R2: host write to outbound message is ignored
        cycle(1'b1, 3'd2, 32'hDEAD_BEEF, 1'b0, 3'd2, '0, "R2");
        idle_read(3'd2, 3'd2, "R2");
        chk("R2", "outbound msg0 unchanged", h_rdata, 32'h0);

        // R4: outbound doorbell reserved bits
        cycle(1'b0, 3'd5, '0, 1'b1, 3'd5, 32'hFFFF_FFFF, "R4");
        idle_read(3'd5, 3'd5, "R4");
        chk("R4", "outbound doorbell value", h_rdata, 32'h1FFF_FFFF);

        // R5/R6: inbound doorbell partial clear keeps status and irq
        cycle(1'b1, 3'd4, 32'h0000_000F, 1'b1, 3'd7, 32'hFFFF_FFF7, "R5");
        cycle(1'b0, 3'd4, '0, 1'b1, 3'd4, 32'h0000_0005, "R5");
        idle_read(3'd4, 3'd6, "R6");
        chk("R5", "partial clear", h_rdata, 32'h0000_000A);
        chk("R6", "doorbell status kept", l_rdata, 32'h0000_0008);
        cycle(1'b0, 3'd4, '0, 1'b1, 3'd6, 32'hFFFF_FFFF, "R6");
        idle_read(3'd4, 3'd6, "R6");
        chk("R6", "status write cannot clear doorbell", l_rdata, 32'h0000_0008);
        chk("R10", "local irq held", {31'b0, local_irq}, 32'h1);
        cycle(1'b0, 3'd4, '0, 1'b1, 3'd4, 32'h0000_000A, "R5");
        idle_read(3'd4, 3'd6, "R5");
        chk("R5", "doorbell emptied", h_rdata, 32'h0);

        // R7: queue and machine-check sources mirror
        cycle(1'b0, 3'd0, '0, 1'b1, 3'd7, 32'h0, "R8");
        mchk_i = 1'b1; ofq_ovf_i = 1'b1;
        idle_read(3'd6, 3'd6, "R7");
        chk("R7", "inbound sources", l_rdata, 32'h0000_0110);
        mchk_i = 1'b0; ofq_ovf_i = 1'b0;
        cycle(1'b0, 3'd0, '0, 1'b1, 3'd7, 32'hFFFF_FFFF, "R8");

        // Constrained random mix
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] hd, ld;
            if ($urandom % 10 == 0) begin
                mchk_i       = 1'($urandom);
                ipq_nempty_i = 1'($urandom);
                ipq_ovf_i    = 1'($urandom);
                ofq_ovf_i    = 1'($urandom);
                opq_nempty_i = 1'($urandom);
            end
            hd = $urandom;
            ld = $urandom;
            if ($urandom % 3 == 0) hd = hd | 32'hFFFF_FF00;
            if ($urandom % 3 == 0) ld = ld | 32'hFFFF_FE00;
            cycle(1'($urandom), 3'($urandom), hd, 1'($urandom), 3'($urandom), ld, "");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule